// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs one operation on a single bit of a byte operand. A three-bit index selects the bit. The unit can force the bit to one or to zero, flip it, or test it. It can also move the bit into the carry flag and move the carry flag back into the bit. Finally, it can fold the bit into the carry flag with AND, OR or XOR, and each of these folds has a form that uses the complement of the bit.

The surrounding pipeline fetches the operand and presents it on one cycle, together with the bit index, an operation code, the current flag nibble and a valid strobe. One clock later the unit returns the updated byte, a write-back enable and the updated flag nibble. The pipeline stores the byte only when the write-back enable is high. Operations that leave the byte alone pass it through unchanged.

Top module: `bitop_unit`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `outValid`, `writeEn`, `resultByte` and `flagsOut` are all zero.
- R2: `outValid` is high exactly one clock after a cycle in which `inValid` was high, and `writeEn` is never high without `outValid`.
- R3: The bit index is `bitNum[2:0]` and the mask is 1 shifted left by that index. Higher bits of `bitNum` have no effect on any output.
- R4: Opcodes 0 (set), 1 (clear) and 2 (flip) return the operand with only the selected bit forced to 1, forced to 0 or inverted, and they raise `writeEn`.
- R5: Opcode 3 (test) sets Z (flag bit 2) to 1 when the selected bit is 0 and clears Z otherwise. It raises no `writeEn`.
- R6: Opcode 4 copies the selected bit into C (flag bit 0). Opcode 5 copies the bit's complement into C. Neither raises `writeEn`.
- R7: Opcode 6 writes C into the selected bit and opcode 7 writes the complement of C. Both raise `writeEn` and leave every other bit unchanged.
- R8: Opcodes 8, 10 and 12 set C to (bit AND C), (bit OR C) and (bit XOR C). Opcodes 9, 11 and 13 do the same with the complement of the bit. None of them raises `writeEn`.
- R9: The flag nibble is {N, Z, V, C} from bit 3 down to bit 0. Every flag that an operation does not name leaves the unit with its `flagsIn` value.
- R10: Opcodes 14 and 15 are no-ops. `writeEn` stays low, `resultByte` equals the operand and `flagsOut` equals `flagsIn`.
- R11: For every operation that raises no `writeEn`, `resultByte` equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation request strobe |
| operand | input | 8 | Byte to operate on |
| bitNum | input | 4 | Bit index; only the low three bits are used |
| opCode | input | 4 | Operation select (0..13; 14 and 15 are no-ops) |
| flagsIn | input | 4 | Current flags {N,Z,V,C} |
| outValid | output | 1 | Result valid, one cycle after the request |
| resultByte | output | 8 | Updated byte |
| writeEn | output | 1 | Byte must be written back |
| flagsOut | output | 4 | Updated flags {N,Z,V,C} |

## Verification
Two functions share one cycle in the carry-driven writes:
- A store reads the incoming carry and rewrites the byte in the same cycle.
- An accumulate reads the selected bit and rewrites the carry in the same cycle.

The bench provokes both by issuing stores and accumulates back-to-back at every bit index with both carry values. It also sets the unused index bit to show that it is ignored. A behavioural model computes the byte, the enable and all four flags for each request, and the bench compares every output on every clock.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int FLAG_W = 4;
  localparam int C_POS  = 0;
  localparam int V_POS  = 1;
  localparam int Z_POS  = 2;
  localparam int N_POS  = 3;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SET   = 4'd0,
    OP_CLR   = 4'd1,
    OP_FLIP  = 4'd2,
    OP_TEST  = 4'd3,
    OP_LDC   = 4'd4,
    OP_LDCN  = 4'd5,
    OP_STC   = 4'd6,
    OP_STCN  = 4'd7,
    OP_ANDC  = 4'd8,
    OP_ANDCN = 4'd9,
    OP_ORC   = 4'd10,
    OP_ORCN  = 4'd11,
    OP_XORC  = 4'd12,
    OP_XORCN = 4'd13,
    OP_NOP0  = 4'd14,
    OP_NOP1  = 4'd15
  } bitOpE;

  typedef enum logic [2:0] {
    SRC_KEEP,
    SRC_ONE,
    SRC_ZERO,
    SRC_FLIP,
    SRC_CARRY,
    SRC_NCARRY
  } bitSrcE;

  typedef enum logic [2:0] {
    CF_KEEP,
    CF_LOAD,
    CF_AND,
    CF_OR,
    CF_XOR
  } carryOpE;

  typedef struct packed {
    logic    doWrite;
    bitSrcE  bitSrc;
    carryOpE carryOp;
    logic    invBit;
    logic    zUpdate;
  } ctrlStrobeT;
endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opCode,
  output ctrlStrobeT      strobe,
  output logic            outValid,
  output logic            writeEn
);

  always_comb begin
    strobe.doWrite = 1'b0;
    strobe.bitSrc  = SRC_KEEP;
    strobe.carryOp = CF_KEEP;
    strobe.invBit  = 1'b0;
    strobe.zUpdate = 1'b0;
    case (bitOpE'(opCode))
      OP_SET:   begin strobe.doWrite = 1'b1; strobe.bitSrc = SRC_ONE;    end
      OP_CLR:   begin strobe.doWrite = 1'b1; strobe.bitSrc = SRC_ZERO;   end
      OP_FLIP:  begin strobe.doWrite = 1'b1; strobe.bitSrc = SRC_FLIP;   end
      OP_TEST:  strobe.zUpdate = 1'b1;
      OP_LDC:   strobe.carryOp = CF_LOAD;
      OP_LDCN:  begin strobe.carryOp = CF_LOAD; strobe.invBit = 1'b1;    end
      OP_STC:   begin strobe.doWrite = 1'b1; strobe.bitSrc = SRC_CARRY;  end
      OP_STCN:  begin strobe.doWrite = 1'b1; strobe.bitSrc = SRC_NCARRY; end
      OP_ANDC:  strobe.carryOp = CF_AND;
      OP_ANDCN: begin strobe.carryOp = CF_AND; strobe.invBit = 1'b1;     end
      OP_ORC:   strobe.carryOp = CF_OR;
      OP_ORCN:  begin strobe.carryOp = CF_OR; strobe.invBit = 1'b1;      end
      OP_XORC:  strobe.carryOp = CF_XOR;
      OP_XORCN: begin strobe.carryOp = CF_XOR; strobe.invBit = 1'b1;     end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      writeEn  <= 1'b0;
    end else begin
      outValid <= inValid;
      writeEn  <= inValid & strobe.doWrite;
    end
  end

  // R2: the result strobe trails the request by one clock
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_wen_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    writeEn |-> outValid);
  // R10: reserved codes never request a write
  a_r10_nop_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode >= 4'd14) |=> !writeEn);
endmodule

// File: rtl/bitop_dp.sv
module bitop_dp
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operand,
  input  logic [SEL_W-1:0]  bitNum,
  input  logic [FLAG_W-1:0] flagsIn,
  input  ctrlStrobeT        strobe,
  output logic [DATA_W-1:0] resultByte,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mask;
  logic              selBit;
  logic              opBit;
  logic              carryIn;
  logic              newBit;
  logic              newCarry;
  logic [DATA_W-1:0] nextByte;
  logic [FLAG_W-1:0] nextFlags;

  assign idx = bitNum[IDX_W-1:0];

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx == IDX_W'(g));
  end

  assign selBit  = |(operand & mask);
  assign opBit   = selBit ^ strobe.invBit;
  assign carryIn = flagsIn[C_POS];

  always_comb begin
    case (strobe.bitSrc)
      SRC_ONE:    newBit = 1'b1;
      SRC_ZERO:   newBit = 1'b0;
      SRC_FLIP:   newBit = ~selBit;
      SRC_CARRY:  newBit = carryIn;
      SRC_NCARRY: newBit = ~carryIn;
      default:    newBit = selBit;
    endcase
    nextByte = (operand & ~mask) | (newBit ? mask : '0);
  end

  always_comb begin
    case (strobe.carryOp)
      CF_LOAD: newCarry = opBit;
      CF_AND:  newCarry = opBit & carryIn;
      CF_OR:   newCarry = opBit | carryIn;
      CF_XOR:  newCarry = opBit ^ carryIn;
      default: newCarry = carryIn;
    endcase
    nextFlags        = flagsIn;
    nextFlags[C_POS] = newCarry;
    if (strobe.zUpdate) nextFlags[Z_POS] = ~selBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultByte <= '0;
      flagsOut   <= '0;
    end else if (inValid) begin
      resultByte <= nextByte;
      flagsOut   <= nextFlags;
    end
  end

  // R4: nothing outside the selected position ever changes
  a_r4_other_bits: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((resultByte ^ $past(operand)) & ~$past(mask)) == '0);
  // R11: non-writing operations pass the byte through
  a_r11_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strobe.doWrite) |=> resultByte == $past(operand));
  // R9: N and V are never touched
  a_r9_nv_keep: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (flagsOut[N_POS] == $past(flagsIn[N_POS])) &&
                (flagsOut[V_POS] == $past(flagsIn[V_POS])));
  // R5: test reports a zero bit through Z
  a_r5_test_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.zUpdate) |=> flagsOut[Z_POS] == !$past(selBit));
  // R8: carry-only operations leave Z alone
  a_r8_z_keep: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobe.carryOp != CF_KEEP) |=> flagsOut[Z_POS] == $past(flagsIn[Z_POS]));
  initial a_r3_idx_fits: assert (SEL_W >= IDX_W);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operand,
  input  logic [SEL_W-1:0]  bitNum,
  input  logic [OP_W-1:0]   opCode,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultByte,
  output logic              writeEn,
  output logic [FLAG_W-1:0] flagsOut
);
  ctrlStrobeT strobe;

  bitop_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .strobe   (strobe),
    .outValid (outValid),
    .writeEn  (writeEn)
  );

  bitop_dp #(.DATA_W(DATA_W), .SEL_W(SEL_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .operand    (operand),
    .bitNum     (bitNum),
    .flagsIn    (flagsIn),
    .strobe     (strobe),
    .resultByte (resultByte),
    .flagsOut   (flagsOut)
  );
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] operand;
  logic [3:0] bitNum;
  logic [3:0] opCode;
  logic [3:0] flagsIn;
  logic       outValid;
  logic [7:0] resultByte;
  logic       writeEn;
  logic [3:0] flagsOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int    expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .bitNum(bitNum), .opCode(opCode), .flagsIn(flagsIn),
    .outValid(outValid), .resultByte(resultByte), .writeEn(writeEn),
    .flagsOut(flagsOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tagFor(int op);
    if (op <= 2) return "R4";
    if (op == 3) return "R5";
    if (op <= 5) return "R6";
    if (op <= 7) return "R7";
    if (op <= 13) return "R8";
    return "R10";
  endfunction

  // packs {valid, we, result[7:0], flags[3:0]}
  function automatic int model(int v, int op, int opd, int bn, int fl);
    int b, c, m, res, we, fo;
    m   = 1 << (bn & 7);
    b   = (opd & m) != 0;
    c   = fl & 1;
    res = opd;
    we  = 0;
    fo  = fl;
    case (op)
      0: begin res = opd | m;  we = 1; end
      1: begin res = opd & ~m; we = 1; end
      2: begin res = opd ^ m;  we = 1; end
      3: fo = b ? (fl & ~4) : (fl | 4);
      4: c = b;
      5: c = !b;
      6: begin res = c ? (opd | m) : (opd & ~m); we = 1; end
      7: begin res = c ? (opd & ~m) : (opd | m); we = 1; end
      8: c = b & c;
      9: c = (!b) & c;
      10: c = b | c;
      11: c = (!b) | c;
      12: c = b ^ c;
      13: c = (!b) ^ c;
      default: ;
    endcase
    fo = (fo & ~1) | c;
    if (!v) we = 0;
    return (v << 13) | (we << 12) | ((res & 255) << 4) | (fo & 15);
  endfunction

  task automatic compare();
    int e;
    string t;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    check("R2", outValid, (e >> 13) & 1);
    check((e >> 12) & 1 ? t : "R11", writeEn, (e >> 12) & 1);
    if ((e >> 13) & 1) begin
      check(((e >> 12) & 1) ? t : "R11", resultByte, (e >> 4) & 255);
      check(t, flagsOut[0] | (flagsOut[2] << 2), e & 5);
      check("R9", flagsOut[3] | (flagsOut[1] << 1), ((e >> 3) & 1) | (e & 2));
    end
  endtask

  task automatic step(int v, int op, int opd, int bn, int fl, string tag = "");
    @(negedge clk);
    compare();
    inValid = v[0];
    opCode  = op[3:0];
    operand = opd[7:0];
    bitNum  = bn[3:0];
    flagsIn = fl[3:0];
    expQ.push_back(model(v, op, opd, bn, fl));
    tagQ.push_back(tag == "" ? tagFor(op) : tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; operand = 8'h5a; bitNum = 4'd0;
    opCode = 4'd0; flagsIn = 4'hf;
    repeat (3) @(negedge clk);
    check("R1", outValid, 0);
    check("R1", writeEn, 0);
    check("R1", resultByte, 0);
    check("R1", flagsOut, 0);
    rstN = 1'b1;
    expQ.push_back(0);
    tagQ.push_back("R1");
    // every opcode on a few patterns
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 4; k++)
        step(1, op, (k == 0) ? 8'h00 : (k == 1) ? 8'hff : (k == 2) ? 8'ha5 : 8'h3c,
             (op + k) & 7, (k & 1) ? 4'b1011 : 4'b0100);
    // stores and accumulates back to back, every index, both carries
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < 2; c++)
        for (int op = 6; op < 14; op++)
          step(1, op, 8'h96 ^ (i * 17), i, 4'b1010 | c);
    // upper index bit must not matter
    for (int i = 0; i < 8; i++) begin
      step(1, 2, 8'h0f, i | 8, 4'h0, "R3");
      step(1, 3, 8'hf0, i | 8, 4'h3, "R3");
      step(0, 0, 8'h00, 0, 0);
    end
    // random traffic with idle gaps
    for (int n = 0; n < 600; n++)
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 256,
           $urandom % 16, $urandom % 16);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule